// File: doc/BRIEF.md
# Ones' Complement Adder-Subtractor

This block is a purely combinational arithmetic unit. It takes two unsigned magnitudes of equal width and either adds them or subtracts the second from the first. Subtraction works by adding the first operand to the bitwise inverse of the second. The result leaves the block as a magnitude with a separate sign bit, which suits datapaths that hold sign and magnitude apart, such as mantissa handling in floating-point units.

The end-around carry of a subtraction can be handled in one of two ways, chosen at build time. In folded mode the block adds the carry back into the least significant bit itself. In exposed mode the block skips that increment and drives the carry on an output instead. A later stage, for example a rounding step that already contains an incrementer, can then apply the correction. In exposed mode the magnitude reads one below the true difference whenever the carry output is high.

Top module: `ones_comp_addsub`

## Requirements
- R1: With sub_i = 0, sign_o is 0 and mag_o equals (a_i + b_i) modulo 2^WIDTH.
- R2: With sub_i = 0, carry_o is bit WIDTH of the full sum a_i + b_i, so it reports magnitude overflow. This holds in both modes.
- R3: In folded mode (EAC_MODE = EAC_FOLD), with sub_i = 1 and a_i > b_i, mag_o = a_i − b_i, sign_o = 0 and carry_o = 0.
- R4: In folded mode, with sub_i = 1 and a_i < b_i, mag_o = b_i − a_i, sign_o = 1 and carry_o = 0.
- R5: With sub_i = 1 and a_i = b_i, mag_o = 0 and sign_o = 0 in both modes. The block never reports a negative zero.
- R6: In exposed mode (EAC_MODE = EAC_EXPOSE), with sub_i = 1 and a_i > b_i, carry_o = 1, sign_o = 0 and mag_o = a_i − b_i − 1. Adding carry_o to mag_o gives the true difference.
- R7: In exposed mode, with sub_i = 1 and a_i < b_i, carry_o = 0, sign_o = 1 and mag_o = b_i − a_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, an unsigned magnitude |
| b_i | input | WIDTH | Second operand, an unsigned magnitude |
| sub_i | input | 1 | 1 selects a_i − b_i; 0 selects a_i + b_i |
| mag_o | output | WIDTH | Magnitude of the result |
| sign_o | output | 1 | 1 when the result is negative |
| carry_o | output | 1 | Addition: overflow. Exposed-mode subtraction: the end-around carry. Folded-mode subtraction: 0 |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies on any path from the inputs to mag_o, sign_o or carry_o. The bench changes the inputs just after a rising clock edge and reads the outputs at the next falling edge. By then the logic has settled half a period earlier, and the following edge has not yet arrived. One instance of each carry mode is driven with the same operands. For the exposed instance, the bench adds carry_o back onto mag_o before it compares against the integer difference.

// File: rtl/oc_pkg.sv
// Shared definitions for the ones' complement adder-subtractor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package oc_pkg;
    // How the end-around carry of a subtraction is handled
    typedef enum logic {
        EAC_FOLD   = 1'b0,   // added back inside the block
        EAC_EXPOSE = 1'b1    // driven on carry_o for a later stage
    } eac_mode_e;
endpackage

// File: rtl/oc_operand_prep.sv
// Conditions the second operand: it passes through for addition and is
// inverted bitwise for subtraction. Purely combinational.
module oc_operand_prep #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             invert_i,
    output logic [WIDTH-1:0] opnd_o
);
    // Conditional inversion, one XOR per bit
    always_comb opnd_o = opnd_i ^ {WIDTH{invert_i}};
endmodule

// File: rtl/oc_ripple_adder.sv
// Unsigned ripple-carry adder with a carry input, built from a chain of
// full-adder cells. Assumes equal-width operands. Purely combinational.
module oc_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH:0] chain;

    // Carry chain entry point
    always_comb chain[0] = cin_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
        // One full-adder cell per bit position
        always_comb begin
            sum_o[k]   = x_i[k] ^ y_i[k] ^ chain[k];
            chain[k+1] = (x_i[k] & y_i[k]) | (chain[k] & (x_i[k] ^ y_i[k]));
        end
    end

    // Carry leaving the top bit
    always_comb cout_o = chain[WIDTH];
endmodule

// File: rtl/oc_result_former.sv
// Turns the raw ones' complement sum into sign plus magnitude. It applies or
// exposes the end-around carry according to MODE and suppresses negative
// zero. Assumes raw_sum_i/raw_cout_i come from a + (sub ? ~b : b).
module oc_result_former
    import oc_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter eac_mode_e MODE  = EAC_FOLD
) (
    input  logic [WIDTH-1:0] raw_sum_i,
    input  logic             raw_cout_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             sign_o,
    output logic             carry_o
);
    logic [WIDTH-1:0] pos_mag;    // magnitude when the difference is >= 0
    logic             sub_carry;  // carry reported for a subtraction
    logic [WIDTH-1:0] neg_mag;    // magnitude when the difference is < 0
    logic             is_neg;

    if (MODE == EAC_FOLD) begin : g_fold
        logic             inc_unused;
        // Add the end-around carry back into the least significant bit
        oc_ripple_adder #(.WIDTH(WIDTH)) u_eac_inc (
            .x_i    (raw_sum_i),
            .y_i    ('0),
            .cin_i  (raw_cout_i),
            .sum_o  (pos_mag),
            .cout_o (inc_unused)
        );
        // The carry is consumed internally, so none is reported
        always_comb sub_carry = 1'b0;
    end else begin : g_expose
        // Leave the raw sum one short and hand the carry to the consumer
        always_comb begin
            pos_mag   = raw_sum_i;
            sub_carry = raw_cout_i;
        end
    end

    // With no carry out, the ones' complement of the raw sum is the magnitude
    always_comb begin
        neg_mag = ~raw_sum_i;
        is_neg  = sub_i & ~raw_cout_i;
    end

    // Select the final fields and keep a zero result positive
    always_comb begin
        if (!sub_i) begin
            mag_o   = raw_sum_i;
            sign_o  = 1'b0;
            carry_o = raw_cout_i;
        end else if (is_neg) begin
            mag_o   = neg_mag;
            sign_o  = |neg_mag;
            carry_o = sub_carry;
        end else begin
            mag_o   = pos_mag;
            sign_o  = 1'b0;
            carry_o = sub_carry;
        end
    end
endmodule

// File: rtl/ones_comp_addsub.sv
// Ones' complement adder-subtractor for unsigned magnitudes, giving sign and
// magnitude. EAC_MODE selects whether the end-around carry is folded back or
// exposed on carry_o. Purely combinational; no clock or reset.
module ones_comp_addsub
    import oc_pkg::*;
#(
    parameter int        WIDTH    = 8,
    parameter eac_mode_e EAC_MODE = EAC_FOLD
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             sign_o,
    output logic             carry_o
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] raw_sum;
    logic             raw_cout;

    oc_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .opnd_i   (b_i),
        .invert_i (sub_i),
        .opnd_o   (b_eff)
    );

    oc_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x_i    (a_i),
        .y_i    (b_eff),
        .cin_i  (1'b0),
        .sum_o  (raw_sum),
        .cout_o (raw_cout)
    );

    oc_result_former #(.WIDTH(WIDTH), .MODE(EAC_MODE)) u_form (
        .raw_sum_i  (raw_sum),
        .raw_cout_i (raw_cout),
        .sub_i      (sub_i),
        .mag_o      (mag_o),
        .sign_o     (sign_o),
        .carry_o    (carry_o)
    );
endmodule

// File: rtl/ones_comp_addsub_chk.sv
// Checker for ones_comp_addsub: immediate assertions on the port relations,
// evaluated whenever the inputs or outputs change. Bound to every instance.
module ones_comp_addsub_chk
    import oc_pkg::*;
#(
    parameter int        WIDTH    = 8,
    parameter eac_mode_e EAC_MODE = EAC_FOLD
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] mag_o,
    input logic             sign_o,
    input logic             carry_o
);
    logic [WIDTH:0]   add_full;
    logic [WIDTH-1:0] diff_ab;
    logic [WIDTH-1:0] diff_ba;
    logic [WIDTH-1:0] mag_plus;

    // Reference arithmetic, computed independently of the design path
    always_comb begin
        add_full = {1'b0, a_i} + {1'b0, b_i};
        diff_ab  = a_i - b_i;
        diff_ba  = b_i - a_i;
        mag_plus = mag_o + {{(WIDTH-1){1'b0}}, carry_o};
    end

    // Port relations that hold for every input combination
    always_comb begin
        if (!sub_i) begin
            AST_ADD_POSITIVE: assert (!sign_o && mag_o == add_full[WIDTH-1:0]); // R1
            AST_ADD_OVERFLOW: assert (carry_o == add_full[WIDTH]); // R2
        end
        AST_NO_NEG_ZERO: assert (!(sign_o && mag_o == '0)); // R5
        if (sub_i && a_i == b_i) begin
            AST_EQUAL_ZERO: assert (mag_o == '0 && !sign_o); // R5
        end
        if (sub_i && EAC_MODE == EAC_FOLD && a_i > b_i) begin
            AST_FOLD_POS_EXACT: assert (!carry_o && !sign_o && mag_o == diff_ab); // R3
        end
        if (sub_i && EAC_MODE == EAC_FOLD && a_i < b_i) begin
            AST_FOLD_NEG_EXACT: assert (!carry_o && sign_o && mag_o == diff_ba); // R4
        end
        if (sub_i && EAC_MODE == EAC_EXPOSE && a_i > b_i) begin
            AST_EXPOSE_SHORT_BY_ONE: assert (carry_o && !sign_o && mag_plus == diff_ab); // R6
        end
        if (sub_i && EAC_MODE == EAC_EXPOSE && a_i < b_i) begin
            AST_EXPOSE_NEG_EXACT: assert (!carry_o && sign_o && mag_o == diff_ba); // R7
        end
    end
endmodule

bind ones_comp_addsub ones_comp_addsub_chk #(
    .WIDTH    (WIDTH),
    .EAC_MODE (EAC_MODE)
) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_i),
    .mag_o   (mag_o),
    .sign_o  (sign_o),
    .carry_o (carry_o)
);

// File: tb/ones_comp_addsub_test.sv
// Bench for ones_comp_addsub: a vector table walked by one loop, then
// directed and sweep tests, on one folded and one exposed instance.
module ones_comp_addsub_test;
    import oc_pkg::*;

    localparam int W = 8;

    typedef struct packed {
        logic         sub;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] mag;   // expected magnitude, folded instance
        logic         sign;
        logic         carry;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0},
        '{1'b0, 8'hF0, 8'h20, 8'h10, 1'b0, 1'b1},
        '{1'b0, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b1},
        '{1'b1, 8'h50, 8'h20, 8'h30, 1'b0, 1'b0},
        '{1'b1, 8'h20, 8'h50, 8'h30, 1'b1, 1'b0},
        '{1'b1, 8'h7F, 8'h7F, 8'h00, 1'b0, 1'b0},
        '{1'b1, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0},
        '{1'b1, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0},
        '{1'b1, 8'h01, 8'h00, 8'h01, 1'b0, 1'b0},
        '{1'b1, 8'h00, 8'h01, 8'h01, 1'b1, 1'b0},
        '{1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
        '{1'b1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         sub = 1'b0;
    logic [W-1:0] mag_f, mag_e;
    logic         sign_f, sign_e, carry_f, carry_e;
    int           n_checks = 0;
    int           n_fail = 0;
    int           cycles = 0;

    always #5 clk = ~clk;   // 100 MHz

    ones_comp_addsub #(.WIDTH(W), .EAC_MODE(EAC_FOLD)) uut (
        .a_i(a), .b_i(b), .sub_i(sub),
        .mag_o(mag_f), .sign_o(sign_f), .carry_o(carry_f)
    );

    ones_comp_addsub #(.WIDTH(W), .EAC_MODE(EAC_EXPOSE)) uut_exp (
        .a_i(a), .b_i(b), .sub_i(sub),
        .mag_o(mag_e), .sign_o(sign_e), .carry_o(carry_e)
    );

    // Requirement covering the folded instance for a given stimulus
    function automatic string req_fold(logic s, logic [W-1:0] x, logic [W-1:0] y);
        if (!s)         return "R1";
        else if (x > y) return "R3";
        else if (x < y) return "R4";
        else            return "R5";
    endfunction

    // Requirement covering the exposed instance for a given stimulus
    function automatic string req_exp(logic s, logic [W-1:0] x, logic [W-1:0] y);
        if (!s)         return "R2";
        else if (x > y) return "R6";
        else if (x < y) return "R7";
        else            return "R5";
    endfunction

    task automatic check(string req, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d (a=%0d b=%0d sub=%0d)",
                     req, what, got, exp, a, b, sub);
        end
    endtask

    // Apply after a rising edge, sample at the following falling edge
    task automatic apply(logic s, logic [W-1:0] x, logic [W-1:0] y);
        @(posedge clk);
        #1;
        sub = s; a = x; b = y;
        @(negedge clk);
    endtask

    // Model-based check of both instances against integer arithmetic
    task automatic check_model();
        int ai = int'(a);
        int bi = int'(b);
        int tot = ai + bi;
        string rf = req_fold(sub, a, b);
        string re = req_exp(sub, a, b);
        if (!sub) begin
            check(rf, "fold mag", int'(mag_f), tot % 256);
            check(rf, "fold sign", int'(sign_f), 0);
            check("R2", "fold carry", int'(carry_f), tot / 256);
            check("R1", "exp mag", int'(mag_e), tot % 256);
            check(re, "exp carry", int'(carry_e), tot / 256);
        end else begin
            int d = (ai >= bi) ? ai - bi : bi - ai;
            int ng = (ai < bi) ? 1 : 0;
            check(rf, "fold mag", int'(mag_f), d);
            check(rf, "fold sign", int'(sign_f), ng);
            check(rf, "fold carry", int'(carry_f), 0);
            check(re, "exp mag+carry", int'(mag_e) + int'(carry_e), d);
            check(re, "exp sign", int'(sign_e), ng);
            check(re, "exp carry", int'(carry_e), (ai > bi) ? 1 : 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got %0d cycles expected below 100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Idle state: all-zero inputs give all-zero outputs (R1)
        @(negedge clk);
        check("R1", "idle fold mag", int'(mag_f), 0);
        check("R1", "idle fold sign", int'(sign_f), 0);
        check("R2", "idle exp carry", int'(carry_e), 0);

        // Table walk against the expected values of the folded instance
        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i].sub, TBL[i].a, TBL[i].b);
            check(req_fold(TBL[i].sub, TBL[i].a, TBL[i].b), "tbl mag",
                  int'(mag_f), int'(TBL[i].mag));
            check(req_fold(TBL[i].sub, TBL[i].a, TBL[i].b), "tbl sign",
                  int'(sign_f), int'(TBL[i].sign));
            check(req_fold(TBL[i].sub, TBL[i].a, TBL[i].b), "tbl carry",
                  int'(carry_f), int'(TBL[i].carry));
            check_model();
        end

        // Directed: exposed mode is one short on a positive difference (R6)
        apply(1'b1, 8'hFF, 8'h00);
        check("R6", "exp raw mag", int'(mag_e), 254);
        check("R6", "exp raw carry", int'(carry_e), 1);

        // Directed: equal operands give positive zero in both modes (R5)
        apply(1'b1, 8'hA5, 8'hA5);
        check("R5", "fold eq sign", int'(sign_f), 0);
        check("R5", "exp eq sign", int'(sign_e), 0);
        check("R5", "exp eq mag", int'(mag_e), 0);

        // Directed: negative exposed result is exact (R7)
        apply(1'b1, 8'h03, 8'h80);
        check("R7", "exp neg mag", int'(mag_e), 125);
        check("R7", "exp neg sign", int'(sign_e), 1);

        // Sweep of operand pairs in both operations (R3, R4)
        for (int x = 0; x < 256; x += 17) begin
            for (int y = 0; y < 256; y += 13) begin
                apply(1'b0, W'(x), W'(y));
                check_model();
                apply(1'b1, W'(x), W'(y));
                check_model();
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule